// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers thirty-two level-sensitive interrupt requests from peripherals and sends each one to one of eight CPU interrupt lines. Software enables each source with its own bit in a mask register. It reads the raw, unmasked level of every request from a status register. It picks the CPU line for each source with a four-bit routing field. A CPU line is high while at least one enabled, active source routed to it stays active.

Software reaches the block over a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and registered read data. The routing fields are packed eight to a word. The word that serves the lowest-numbered sources sits at the highest routing offset. The CPU lines are registered and active-high, and they follow the inputs and the registers with one cycle of delay.

Top module: `lvl_irq_router`

## Requirements
- R1: After synchronous reset, the mask register reads zero and all four routing registers read zero. All CPU lines are low and read data is zero.
- R2: The mask register is read/write at offset 0x00. Bit n enables source n.
- R3: The status register sits at offset 0x04. Bit n reads the current level of input n. A write to 0x04 changes no register and no output.
- R4: Routing registers are read/write at offsets 0x08, 0x0C, 0x10 and 0x14.
- R5: The routing field of source s is bits 4*(s mod 8)+3 down to 4*(s mod 8) of one register. Sources 0–7 use 0x14, 8–15 use 0x10, 16–23 use 0x0C and 24–31 use 0x08.
- R6: CPU line k is high exactly when some source s has its mask bit set, its input high and a routing field equal to k (k in 0..7).
- R7: A source whose routing field holds 8 to 15 drives no CPU line.
- R8: Lines are level-type. A line stays high for as long as its contributing source stays active and enabled. It drops when the source deasserts or its mask bit is cleared.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 returns zero, including offsets that are not word-aligned.
- R10: An input or register change shows on the CPU lines at the clock edge after the edge that captures it. Read data for an address appears at the edge after the address is presented, and it reflects register contents before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Level-sensitive interrupt requests, one per source |
| cpu_irq | output | 8 | Registered active-high CPU interrupt lines |

## Verification
Four properties are checked on every cycle:
- A mask write lands exactly as written.
- Status reads echo the request inputs of the previous cycle.
- Unmapped reads give zero.
- No CPU line rises unless some enabled source was active the cycle before, and with an all-zero mask every line stays low.

The exact steering of each source to its line, the reversed placement of the routing words, the unrouted field values and the holding and dropping of levels over many cycles can only be shown by the bench. It drives directed and seeded random sequences and compares the bench's own model of the registers and lines against the design.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned OFS_MASK   = 'h00;
  localparam int unsigned OFS_STAT   = 'h04;
  localparam int unsigned OFS_ROUTE0 = 'h08;
  localparam int unsigned WORD_BYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_ROUTE = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC        = 32,
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned NUM_ROUTE_REGS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             bus_wr,
  input  logic [DATA_W-1:0]                bus_wdata,
  input  logic [NUM_SRC-1:0]               irq_in,
  output logic [DATA_W-1:0]                bus_rdata,
  output logic [NUM_SRC-1:0]               mask_q,
  output logic [NUM_ROUTE_REGS*DATA_W-1:0] route_flat
);
  localparam int unsigned RIDX_W = (NUM_ROUTE_REGS > 1) ? $clog2(NUM_ROUTE_REGS) : 1;

  reg_sel_e                  sel;
  logic [RIDX_W-1:0]         ridx;
  logic [NUM_ROUTE_REGS-1:0] route_hit;
  logic [DATA_W-1:0]         rd_next;

  // Address decode
  generate
    for (genvar r = 0; r < NUM_ROUTE_REGS; r++) begin : g_hit
      assign route_hit[r] = (bus_addr == ADDR_W'(OFS_ROUTE0 + r * WORD_BYTES));
    end
  endgenerate

  always_comb begin
    sel  = SEL_NONE;
    ridx = '0;
    if (bus_addr == ADDR_W'(OFS_MASK)) begin
      sel = SEL_MASK;
    end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
      sel = SEL_STAT;
    end else begin
      for (int r = 0; r < NUM_ROUTE_REGS; r++) begin
        if (route_hit[r]) begin
          sel  = SEL_ROUTE;
          ridx = RIDX_W'(r);
        end
      end
    end
  end

  // Mask register
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (bus_wr && sel == SEL_MASK) begin
      mask_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  // Routing registers, one per group of sources
  generate
    for (genvar r = 0; r < NUM_ROUTE_REGS; r++) begin : g_route
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
        end else if (bus_wr && route_hit[r]) begin
          word_q <= bus_wdata;
        end
      end
      assign route_flat[r*DATA_W +: DATA_W] = word_q;
    end
  endgenerate

  // Readback multiplexer, registered
  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_MASK:  rd_next = DATA_W'(mask_q);
      SEL_STAT:  rd_next = DATA_W'(irq_in);
      SEL_ROUTE: rd_next = route_flat[ridx*DATA_W +: DATA_W];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_next;
    end
  end

  // R2
  mask_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

  // R3
  status_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == ADDR_W'(OFS_STAT)) |-> (bus_rdata == DATA_W'($past(irq_in))));

  // R3
  status_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_STAT)) |=> (mask_q == $past(mask_q) && route_flat == $past(route_flat)));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) != ADDR_W'(OFS_MASK) && $past(bus_addr) != ADDR_W'(OFS_STAT)
     && $past(route_hit) == '0) |-> (bus_rdata == '0));
endmodule

// File: rtl/irq_line_steer.sv
module irq_line_steer
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC        = 32,
  parameter int unsigned NUM_LINES      = 8,
  parameter int unsigned FIELD_W        = 4,
  parameter int unsigned NUM_ROUTE_REGS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_SRC-1:0]               mask_q,
  input  logic [NUM_SRC-1:0]               irq_in,
  input  logic [NUM_ROUTE_REGS*DATA_W-1:0] route_flat,
  output logic [NUM_LINES-1:0]             cpu_irq
);
  localparam int unsigned SRC_PER_REG = DATA_W / FIELD_W;

  logic [NUM_SRC-1:0]                live;
  logic [NUM_LINES-1:0][NUM_SRC-1:0] line_src;
  logic [NUM_LINES-1:0]              lines_next;

  assign live = mask_q & irq_in;

  // Per-source field extraction: lowest sources live in the last word
  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int unsigned REG_IDX = NUM_ROUTE_REGS - 1 - (s / SRC_PER_REG);
      localparam int unsigned BIT_POS = REG_IDX * DATA_W + FIELD_W * (s % SRC_PER_REG);
      logic [FIELD_W-1:0] fld;
      assign fld = route_flat[BIT_POS +: FIELD_W];
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_ln
        assign line_src[k][s] = live[s] && (fld == FIELD_W'(k));
      end
    end
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_or
      assign lines_next[k] = |line_src[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq <= '0;
    end else begin
      cpu_irq <= lines_next;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (cpu_irq == '0));

  // R8
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> (cpu_irq == '0));

  // R6
  line_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq != '0) |-> ($past(live) != '0));

  // R6
  lines_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(cpu_irq) <= $countones($past(live))));
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   irq_in,
  output logic [NUM_LINES-1:0] cpu_irq
);
  localparam int unsigned SRC_PER_REG    = DATA_W / FIELD_W;
  localparam int unsigned NUM_ROUTE_REGS = (NUM_SRC + SRC_PER_REG - 1) / SRC_PER_REG;

  logic [NUM_SRC-1:0]               mask_q;
  logic [NUM_ROUTE_REGS*DATA_W-1:0] route_flat;

  irq_reg_bank #(
    .NUM_SRC        (NUM_SRC),
    .ADDR_W         (ADDR_W),
    .NUM_ROUTE_REGS (NUM_ROUTE_REGS)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .irq_in     (irq_in),
    .bus_rdata  (bus_rdata),
    .mask_q     (mask_q),
    .route_flat (route_flat)
  );

  irq_line_steer #(
    .NUM_SRC        (NUM_SRC),
    .NUM_LINES      (NUM_LINES),
    .FIELD_W        (FIELD_W),
    .NUM_ROUTE_REGS (NUM_ROUTE_REGS)
  ) u_steer (
    .clk        (clk),
    .rst        (rst),
    .mask_q     (mask_q),
    .irq_in     (irq_in),
    .route_flat (route_flat),
    .cpu_irq    (cpu_irq)
  );
endmodule

// File: tb/sim_lvl_irq_router.sv
module sim_lvl_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic [7:0]  cpu_irq;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mask_m;
  logic [31:0] route_m [4];  // index 0 = offset 0x08

  always #10 clk = ~clk;

  lvl_irq_router u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_irq(cpu_irq)
  );

  function automatic logic [7:0] model_lines(input logic [31:0] irq);
    logic [7:0] o = '0;
    for (int s = 0; s < 32; s++) begin
      logic [3:0] f = route_m[3 - s/8][4*(s%8) +: 4];  // R5 placement
      if (mask_m[s] && irq[s] && f < 4'd8) o[f[2:0]] = 1'b1;  // R6, R7
    end
    return o;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic [31:0] irq);
    case (a)
      8'h00: return mask_m;
      8'h04: return irq;
      8'h08: return route_m[0];
      8'h0C: return route_m[1];
      8'h10: return route_m[2];
      8'h14: return route_m[3];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08, 8'h0C, 8'h10, 8'h14: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at negedge, predict from pre-edge model, check after edge (R10)
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] irq, input string tag);
    logic [7:0]  exp_o;
    logic [31:0] exp_r;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; irq_in = irq;
    exp_o = model_lines(irq);
    exp_r = model_read(a, irq);
    @(posedge clk);
    if (wr) begin
      case (a)
        8'h00: mask_m = d;
        8'h08: route_m[0] = d;
        8'h0C: route_m[1] = d;
        8'h10: route_m[2] = d;
        8'h14: route_m[3] = d;
        default: ;  // R3: status and unmapped writes change nothing
      endcase
    end
    #2;
    chk({tag, " lines R10"}, {24'h0, cpu_irq}, {24'h0, exp_o});
    chk({read_tag(a), " rdata R10"}, bus_rdata, exp_r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] irq;
    logic [7:0]  addrs [8];
    void'($urandom(32'd20240611));
    mask_m = '0;
    for (int i = 0; i < 4; i++) route_m[i] = '0;
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h02};

    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state at the ports
    chk("R1 lines", {24'h0, cpu_irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    step(0, 8'h00, 0, 32'hFFFF_FFFF, "R1");
    step(0, 8'h08, 0, 32'hFFFF_FFFF, "R1");
    step(0, 8'h0C, 0, 32'hFFFF_FFFF, "R1");
    step(0, 8'h10, 0, 32'hFFFF_FFFF, "R1");
    step(0, 8'h14, 0, 32'hFFFF_FFFF, "R1");

    // R5: source 0 through bits 3:0 of 0x14 to line 5
    step(1, 8'h14, 32'h0000_0005, 32'h0, "R5");
    step(1, 8'h00, 32'h0000_0001, 32'h0, "R2");
    step(0, 8'h14, 0, 32'h0000_0001, "R5");
    step(0, 8'h00, 0, 32'h0000_0001, "R5");  // line 5 expected high
    // R5: source 31 through bits 31:28 of 0x08 to line 2
    step(1, 8'h08, 32'h2000_0000, 32'h0000_0001, "R5");
    step(1, 8'h00, 32'h8000_0001, 32'h8000_0001, "R5");
    step(0, 8'h04, 0, 32'h8000_0001, "R5");
    // R7: source 9 given field 9 in bits 7:4 of 0x10
    step(1, 8'h10, 32'h0000_0090, 32'h0000_0200, "R7");
    step(1, 8'h00, 32'h0000_0200, 32'h0000_0200, "R7");
    step(0, 8'h10, 0, 32'h0000_0200, "R7");  // no line may rise
    step(0, 8'h10, 0, 32'h0000_0200, "R7");
    // R3: status write is ignored
    step(1, 8'h04, 32'hFFFF_FFFF, 32'h0000_0200, "R3");
    step(0, 8'h00, 0, 32'h0000_0200, "R3");
    // R8: level hold, then drop by input, then by mask
    step(1, 8'h00, 32'h0000_0001, 32'h0000_0001, "R8");
    for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 32'h0000_0001, "R8");
    step(0, 8'h00, 0, 32'h0, "R8");
    step(0, 8'h00, 0, 32'h0000_0001, "R8");
    step(1, 8'h00, 32'h0, 32'h0000_0001, "R8");
    step(0, 8'h00, 0, 32'h0000_0001, "R8");
    // R9: unmapped and unaligned offsets
    step(0, 8'h18, 0, 32'hFFFF_FFFF, "R9");
    step(0, 8'h02, 0, 32'hFFFF_FFFF, "R9");
    step(1, 8'hFC, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
    step(0, 8'hFC, 0, 32'hFFFF_FFFF, "R9");

    // Seeded random traffic: R6 across all encodings
    irq = $urandom;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic       wr;
      a  = ($urandom_range(0, 9) < 8) ? addrs[$urandom_range(0, 7)] : 8'($urandom);
      wr = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 3) == 0) irq = irq ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 49) == 0) irq = $urandom;
      step(wr, a, $urandom, irq, "R6");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule